// File: doc/BRIEF.md
# SPI Slave Byte Mover with Memory Port

This block is an SPI slave endpoint that moves a programmed number of bytes between the SPI bus and a byte-wide synchronous memory port. Each job runs in one direction only. In receive jobs, bytes arriving on MOSI are stored at consecutive addresses. In transmit jobs, bytes are read from consecutive addresses and shifted out on MISO. The SPI clock and chip select come from an external master. They are synchronized into the system clock domain, which must run at least four times faster than SCLK. The bus uses mode 0: MOSI is sampled on the rising edge, MISO changes after the falling edge, and the most significant bit goes first.

Software writes a byte length, a start address and a control word. The control word holds a go bit, a two-bit command field that must equal 3, and a direction bit. A transmit job also waits until software sets a data-ready bit. When the job ends, the block raises a level interrupt. Software acknowledges it by writing 1 to the interrupt status bit. If chip select rises before the length is reached, the job ends early and a short-transfer flag is set. A soft-reset write aborts any job.

Register map (word index on `reg_addr`): 0 = control (bit0 go, bit1 soft reset, write-only, bits[3:2] command, bit6 direction with 1 meaning transmit), 1 = length in bytes, 2 = start address, 3 = status (bit0 data ready, bit4 busy, bit8 interrupt pending, bit9 short transfer).

Top module: `spi_dma_slave`

## Requirements
- R1: After reset, `irq` is low, the status register reads 0, `miso_oe` is low and `mem_en` is low.
- R2: A job starts only when control bit0 is 1 and bits[3:2] equal 3. With any other command code, SPI traffic writes no memory and raises no interrupt.
- R3: In a receive job (control bit6 = 0), each byte taken MSB first from MOSI on rising SCLK edges while `cs_n` is low is written to the start address plus its byte index.
- R4: A transmit job (control bit6 = 1) does not start until software writes 1 to status bit0. Before that, `miso_oe` stays low and no interrupt is raised.
- R5: In a transmit job, the bytes at the start address plus their index appear on MISO MSB first. The first bit is valid when `cs_n` falls, and each later bit changes after a falling SCLK edge.
- R6: `miso_oe` is high only while a transmit job is active and `cs_n` is low.
- R7: After the programmed number of bytes, busy (status bit4) clears, and `irq` and status bit8 go to 1.
- R8: Writing 1 to status bit8 clears `irq`, bit8 and bit9. Writing 0 to bit8 leaves them set.
- R9: If `cs_n` rises before the length is reached, the job ends with `irq` set and status bit9 set. A partly received byte is not written.
- R10: Writing control bit1 aborts the running job and clears busy. Further SPI traffic writes no memory and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a read is sampled |
| sclk | input | 1 | SPI clock from master |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Master-out data |
| miso | output | 1 | Slave-out data |
| miso_oe | output | 1 | Output enable for MISO |
| irq | output | 1 | Job-complete interrupt, level |

## Verification
The hardest case to reach is the transmit path at a byte boundary. The next byte has to be fetched through a two-cycle memory read and loaded into the shifter between the eighth rising edge and the following falling edge, and the data-ready gate must be in place. The bench first drives a full chip-select burst while the job is only armed, then sets data-ready and clocks three consecutive bytes with distinct bit patterns. It also cuts chip select in the middle of a byte to reach the short-transfer ending with a partial byte pending.

// File: rtl/spi_dma_pkg.sv
// Shared constants for the SPI slave byte mover: register indices,
// field positions and the command code that validates a job.
package spi_dma_pkg;
    localparam logic [1:0] REG_CTRL = 2'd0;
    localparam logic [1:0] REG_LEN  = 2'd1;
    localparam logic [1:0] REG_BASE = 2'd2;
    localparam logic [1:0] REG_STAT = 2'd3;

    localparam int CTRL_GO   = 0;
    localparam int CTRL_SRST = 1;
    localparam int CTRL_CMD  = 2;
    localparam int CTRL_DIR  = 6;

    localparam int STAT_RDY   = 0;
    localparam int STAT_BUSY  = 4;
    localparam int STAT_IRQ   = 8;
    localparam int STAT_SHORT = 9;

    localparam logic [1:0] CMD_VALID = 2'b11;
endpackage

// File: rtl/spi_pin_sync.sv
// Brings SCLK, CS_n and MOSI into the system clock domain through two flops
// and derives single-cycle edge pulses. Assumes clk >= 4x SCLK.
module spi_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic mosi,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_act,
    output logic cs_start,
    output logic cs_end,
    output logic mosi_s
);
    logic [2:0] sclk_q;
    logic [2:0] cs_q;
    logic [1:0] mosi_q;

    // Shift the raw pins through the synchronizer chains.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            mosi_q <= '0;
        end else begin
            sclk_q <= {sclk_q[1:0], sclk};
            cs_q   <= {cs_q[1:0], cs_n};
            mosi_q <= {mosi_q[0], mosi};
        end
    end

    assign sclk_rise = sclk_q[1] & ~sclk_q[2];
    assign sclk_fall = ~sclk_q[1] & sclk_q[2];
    assign cs_act    = ~cs_q[1];
    assign cs_start  = ~cs_q[1] & cs_q[2];
    assign cs_end    = cs_q[1] & ~cs_q[2];
    assign mosi_s    = mosi_q[1];
endmodule

// File: rtl/spi_dma_regs.sv
// Software-visible registers: control, length, start address and status.
// Produces the launch pulse, the soft-reset pulse and the interrupt level.
// Assumes the engine raises busy in the cycle after launch.
module spi_dma_regs
    import spi_dma_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              job_done,
    input  logic              job_short,
    output logic              launch,
    output logic              dir_tx,
    output logic [LEN_W-1:0]  job_len,
    output logic [ADDR_W-1:0] job_base,
    output logic              soft_rst,
    output logic              irq
);
    logic       go_q, dir_q, rdy_q, irq_q, short_q;
    logic [1:0] cmd_q;
    logic       wr_ctrl, wr_stat, ack;

    assign wr_ctrl  = reg_we && (reg_addr == REG_CTRL);
    assign wr_stat  = reg_we && (reg_addr == REG_STAT);
    assign soft_rst = wr_ctrl && reg_wdata[CTRL_SRST];
    assign ack      = wr_stat && reg_wdata[STAT_IRQ];
    assign launch   = go_q && (cmd_q == CMD_VALID) && !busy && (!dir_q || rdy_q);

    // Control fields: written by software, go and ready consumed at launch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q  <= 1'b0;
            dir_q <= 1'b0;
            cmd_q <= '0;
            rdy_q <= 1'b0;
        end else if (soft_rst) begin
            go_q  <= 1'b0;
            dir_q <= 1'b0;
            cmd_q <= '0;
            rdy_q <= 1'b0;
        end else begin
            if (launch) begin
                go_q <= 1'b0;
                if (dir_q) rdy_q <= 1'b0;
            end
            if (wr_ctrl) begin
                go_q  <= reg_wdata[CTRL_GO];
                dir_q <= reg_wdata[CTRL_DIR];
                cmd_q <= reg_wdata[CTRL_CMD+1:CTRL_CMD];
            end
            if (wr_stat && reg_wdata[STAT_RDY]) rdy_q <= 1'b1;
        end
    end

    // Length and start address hold their values until rewritten.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            job_len  <= '0;
            job_base <= '0;
        end else begin
            if (reg_we && reg_addr == REG_LEN)  job_len  <= reg_wdata[LEN_W-1:0];
            if (reg_we && reg_addr == REG_BASE) job_base <= reg_wdata[ADDR_W-1:0];
        end
    end

    // Interrupt and short flag: set at job end, cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q   <= 1'b0;
            short_q <= 1'b0;
        end else if (job_done) begin
            irq_q   <= 1'b1;
            short_q <= job_short;
        end else if (ack) begin
            irq_q   <= 1'b0;
            short_q <= 1'b0;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                reg_rdata[CTRL_GO]                 = go_q;
                reg_rdata[CTRL_CMD+1:CTRL_CMD]     = cmd_q;
                reg_rdata[CTRL_DIR]                = dir_q;
            end
            REG_LEN:  reg_rdata[LEN_W-1:0]  = job_len;
            REG_BASE: reg_rdata[ADDR_W-1:0] = job_base;
            default: begin
                reg_rdata[STAT_RDY]   = rdy_q;
                reg_rdata[STAT_BUSY]  = busy;
                reg_rdata[STAT_IRQ]   = irq_q;
                reg_rdata[STAT_SHORT] = short_q;
            end
        endcase
    end

    assign dir_tx = dir_q;
    assign irq    = irq_q;

    // R8: a pending interrupt stays until acknowledged.
    p_irq_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q && !ack |=> irq_q);
    // R9: the short flag never stands without a pending interrupt.
    p_short_has_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        short_q |-> irq_q);
endmodule

// File: rtl/spi_dma_engine.sv
// Job engine: the receive shifter with memory writes, and the transmit
// prefetch with the output shifter. Memory reads return data one cycle
// after the request is sampled. Assumes clk >= 4x SCLK.
module spi_dma_engine #(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              launch,
    input  logic              dir_tx_in,
    input  logic [LEN_W-1:0]  len,
    input  logic [ADDR_W-1:0] base,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              cs_act,
    input  logic              cs_start,
    input  logic              cs_end,
    input  logic              mosi_s,
    input  logic [7:0]        mem_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              miso,
    output logic              miso_oe,
    output logic              busy,
    output logic              done,
    output logic              short_end
);
    logic              busy_q, tx_q, done_q, short_q;
    logic [LEN_W-1:0]  len_q, byte_cnt, fetch_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [2:0]        bit_cnt;
    logic [6:0]        rx_sh;
    logic [7:0]        tx_sh, nxt_buf;
    logic              nxt_valid, cur_valid, rd_p1, rd_p2;
    logic              en_q, we_q;
    logic [ADDR_W-1:0] maddr_q;
    logic [7:0]        wdata_q;

    // Job sequencing, shifting and memory requests.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy_q <= 1'b0; tx_q <= 1'b0; done_q <= 1'b0; short_q <= 1'b0;
            len_q <= '0; byte_cnt <= '0; fetch_cnt <= '0; addr_q <= '0;
            bit_cnt <= '0; rx_sh <= '0; tx_sh <= '0; nxt_buf <= '0;
            nxt_valid <= 1'b0; cur_valid <= 1'b0; rd_p1 <= 1'b0; rd_p2 <= 1'b0;
            en_q <= 1'b0; we_q <= 1'b0; maddr_q <= '0; wdata_q <= '0;
        end else begin
            en_q   <= 1'b0;
            we_q   <= 1'b0;
            done_q <= 1'b0;
            rd_p1  <= 1'b0;
            rd_p2  <= rd_p1;
            if (launch) begin
                tx_q      <= dir_tx_in;
                len_q     <= len;
                addr_q    <= base;
                byte_cnt  <= '0;
                fetch_cnt <= '0;
                bit_cnt   <= '0;
                nxt_valid <= 1'b0;
                cur_valid <= 1'b0;
                short_q   <= 1'b0;
                if (len == '0) done_q <= 1'b1;
                else           busy_q <= 1'b1;
            end else if (busy_q) begin
                if (cs_start) bit_cnt <= '0;
                if (tx_q) begin
                    if (!rd_p1 && !rd_p2 && !nxt_valid && fetch_cnt < len_q) begin
                        en_q      <= 1'b1;
                        maddr_q   <= addr_q;
                        addr_q    <= addr_q + 1'b1;
                        fetch_cnt <= fetch_cnt + 1'b1;
                        rd_p1     <= 1'b1;
                    end
                    if (rd_p2) begin
                        nxt_buf   <= mem_rdata;
                        nxt_valid <= 1'b1;
                    end
                    if (!cur_valid && nxt_valid) begin
                        tx_sh     <= nxt_buf;
                        cur_valid <= 1'b1;
                        nxt_valid <= 1'b0;
                    end
                    if (sclk_fall && cs_act && bit_cnt != '0)
                        tx_sh <= {tx_sh[6:0], 1'b0};
                end
                if (sclk_rise && cs_act) begin
                    bit_cnt <= bit_cnt + 1'b1;
                    if (!tx_q) rx_sh <= {rx_sh[5:0], mosi_s};
                    if (bit_cnt == 3'd7) begin
                        byte_cnt <= byte_cnt + 1'b1;
                        if (!tx_q) begin
                            en_q    <= 1'b1;
                            we_q    <= 1'b1;
                            maddr_q <= addr_q;
                            wdata_q <= {rx_sh, mosi_s};
                            addr_q  <= addr_q + 1'b1;
                        end else begin
                            tx_sh     <= nxt_buf;
                            nxt_valid <= 1'b0;
                        end
                        if (byte_cnt == len_q - 1'b1) begin
                            busy_q <= 1'b0;
                            done_q <= 1'b1;
                        end
                    end
                end else if (cs_end) begin
                    busy_q  <= 1'b0;
                    done_q  <= 1'b1;
                    short_q <= 1'b1;
                end
            end
        end
    end

    assign mem_en    = en_q;
    assign mem_we    = we_q;
    assign mem_addr  = maddr_q;
    assign mem_wdata = wdata_q;
    assign miso      = tx_sh[7];
    assign miso_oe   = busy_q && tx_q && cs_act;
    assign busy      = busy_q;
    assign done      = done_q;
    assign short_end = short_q;

    // R5: prefetch never reads past the programmed length.
    p_fetch_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_cnt <= len_q);
    // R7: the completion pulse coincides with an idle engine.
    p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q);
    // R10: memory is touched only by a job that was running a cycle earlier.
    p_mem_in_job_r10: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> $past(busy_q));
    // R3: memory writes come only from receive jobs.
    p_write_rx_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_q && we_q |-> !tx_q);
endmodule

// File: rtl/spi_dma_slave.sv
// Top level of the SPI slave byte mover: pin synchronizer, register file
// and job engine. Synchronous active-low reset, clk >= 4x SCLK.
module spi_dma_slave #(
    parameter int LEN_W  = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic              irq
);
    logic sclk_rise, sclk_fall, cs_act, cs_start, cs_end, mosi_s;
    logic busy, done, short_end, launch, dir_tx, soft_rst;
    logic [LEN_W-1:0]  job_len;
    logic [ADDR_W-1:0] job_base;

    spi_pin_sync u_sync (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act),
        .cs_start(cs_start), .cs_end(cs_end), .mosi_s(mosi_s)
    );

    spi_dma_regs #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
        .job_done(done), .job_short(short_end), .launch(launch),
        .dir_tx(dir_tx), .job_len(job_len), .job_base(job_base),
        .soft_rst(soft_rst), .irq(irq)
    );

    spi_dma_engine #(.LEN_W(LEN_W), .ADDR_W(ADDR_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .abort(soft_rst), .launch(launch),
        .dir_tx_in(dir_tx), .len(job_len), .base(job_base),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_act(cs_act),
        .cs_start(cs_start), .cs_end(cs_end), .mosi_s(mosi_s),
        .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .miso(miso),
        .miso_oe(miso_oe), .busy(busy), .done(done), .short_end(short_end)
    );
endmodule

// File: tb/spi_dma_slave_bench.sv
// Directed bench: one task per scenario, SPI master model in mode 0.
module spi_dma_slave_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_en, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic        miso, miso_oe, irq;
    logic [7:0]  mem [256];
    int          n_chk = 0, n_fail = 0;
    bit          finished = 0;

    always #10 clk = ~clk;

    spi_dma_slave u_spi_dma_slave (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .irq(irq)
    );

    // Synchronous byte memory model.
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Mode 0 byte exchange, half period of 8 system cycles.
    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int i = 7; i > 7 - nbits; i--) begin
            mosi = tx[i];
            wcyc(8);
            rx[i] = miso;
            sclk = 1'b1;
            wcyc(8);
            sclk = 1'b0;
        end
    endtask

    task automatic cs_low();
        cs_n = 1'b0;
        wcyc(8);
    endtask

    task automatic cs_high();
        wcyc(8);
        cs_n = 1'b1;
        wcyc(12);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd3, d);
        chk("R1 status", d, 32'h0);
        chk("R1 irq", irq, 0);
        chk("R1 miso_oe", miso_oe, 0);
        chk("R1 mem_en", mem_en, 0);
    endtask

    task automatic t_rx();
        logic [7:0] r;
        logic [31:0] d;
        wr(2'd1, 3); wr(2'd2, 32'h10); wr(2'd0, 32'h0D);
        wcyc(4);
        cs_low();
        xfer(8'hA5, 8, r); xfer(8'h3C, 8, r); xfer(8'hF0, 8, r);
        cs_high();
        chk("R3 byte0", mem[8'h10], 8'hA5);
        chk("R3 byte1", mem[8'h11], 8'h3C);
        chk("R3 byte2", mem[8'h12], 8'hF0);
        chk("R7 irq", irq, 1);
        rd(2'd3, d);
        chk("R7 status", d, 32'h100);
        wr(2'd3, 32'h0);
        chk("R8 write zero keeps irq", irq, 1);
        wr(2'd3, 32'h100);
        chk("R8 ack clears irq", irq, 0);
    endtask

    task automatic t_bad_cmd();
        logic [7:0] r;
        mem[8'h20] = 8'h00;
        wr(2'd1, 1); wr(2'd2, 32'h20); wr(2'd0, 32'h05);
        wcyc(4);
        cs_low(); xfer(8'h77, 8, r); cs_high();
        chk("R2 no write", mem[8'h20], 8'h00);
        chk("R2 no irq", irq, 0);
        wr(2'd0, 32'h2);
    endtask

    task automatic t_tx();
        logic [7:0] r0, r1, r2, r;
        logic [31:0] d;
        mem[8'h40] = 8'h81; mem[8'h41] = 8'h7E; mem[8'h42] = 8'hC3;
        wr(2'd1, 3); wr(2'd2, 32'h40); wr(2'd0, 32'h4D);
        wcyc(4);
        cs_low();
        chk("R4 oe before ready", miso_oe, 0);
        xfer(8'h00, 8, r);
        cs_high();
        chk("R4 no irq before ready", irq, 0);
        chk("R6 oe with cs high", miso_oe, 0);
        wr(2'd3, 32'h1);
        wcyc(10);
        cs_low();
        chk("R6 oe during job", miso_oe, 1);
        xfer(8'h00, 8, r0); xfer(8'h00, 8, r1); xfer(8'h00, 8, r2);
        chk("R5 byte0", r0, 8'h81);
        chk("R5 byte1", r1, 8'h7E);
        chk("R5 byte2", r2, 8'hC3);
        cs_high();
        chk("R6 oe after job", miso_oe, 0);
        chk("R7 tx irq", irq, 1);
        rd(2'd3, d);
        chk("R7 tx status", d, 32'h100);
        wr(2'd3, 32'h100);
    endtask

    task automatic t_short();
        logic [7:0] r;
        logic [31:0] d;
        mem[8'h60] = 0; mem[8'h61] = 0; mem[8'h62] = 0;
        wr(2'd1, 4); wr(2'd2, 32'h60); wr(2'd0, 32'h0D);
        wcyc(4);
        cs_low();
        xfer(8'h12, 8, r); xfer(8'h34, 8, r); xfer(8'hFF, 3, r);
        cs_high();
        chk("R9 irq", irq, 1);
        rd(2'd3, d);
        chk("R9 status short", d, 32'h300);
        chk("R9 byte0", mem[8'h60], 8'h12);
        chk("R9 byte1", mem[8'h61], 8'h34);
        chk("R9 partial dropped", mem[8'h62], 8'h00);
        wr(2'd3, 32'h100);
        rd(2'd3, d);
        chk("R8 ack clears short", d, 32'h0);
    endtask

    task automatic t_srst();
        logic [7:0] r;
        logic [31:0] d;
        mem[8'h80] = 0; mem[8'h81] = 0;
        wr(2'd1, 2); wr(2'd2, 32'h80); wr(2'd0, 32'h0D);
        wcyc(4);
        cs_low();
        xfer(8'h5A, 8, r);
        wr(2'd0, 32'h2);
        rd(2'd3, d);
        chk("R10 busy cleared", d, 32'h0);
        xfer(8'hC7, 8, r);
        cs_high();
        chk("R10 first byte kept", mem[8'h80], 8'h5A);
        chk("R10 no write after abort", mem[8'h81], 8'h00);
        chk("R10 no irq", irq, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        wcyc(5);
        rst_n = 1'b1;
        wcyc(2);
        t_reset();
        t_rx();
        t_bad_cmd();
        t_tx();
        t_short();
        t_srst();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule